// File: doc/BRIEF.md
# Dual-Mode Ethernet Receive Byte Assembler

This block sits between an external Ethernet physical-layer device and a MAC. It turns the receive data into a byte stream. It works in one of two modes.

In nibble mode it takes a 4-bit nibble on every receive clock while the data-valid line is high. In serial mode it takes one bit per clock from data line 0. Both modes feed the same shift register. Bytes are marked with start-of-frame and end-of-frame strobes. A frame-level error flag goes out together with the last byte.

Carrier-sense and collision come from the medium and are not aligned to any clock. Each passes through a two-flop synchroniser. The synchronised collision output is held low while the block is set for full duplex. Only the frame delimiter is interpreted: frame check sequence checking, preamble removal and storage are left to the MAC.

Top module: `eth_rx_front`

## Requirements
- R1: In nibble mode (`serial_mode`=0) one nibble of `rx_data` is taken on each clock with `rx_valid` high. The first nibble of each pair becomes byte bits 3:0 and the second becomes bits 7:4.
- R2: In serial mode (`serial_mode`=1) only `rx_data[0]` is taken, one bit per clock, least significant bit first. A byte completes after every eighth bit, and `rx_data[3:1]` has no effect.
- R3: While `rx_valid` is low, `rx_data` and `rx_err` have no effect: they add no byte and cause no error flag in any frame.
- R4: `byte_sof` is high together with `byte_valid` on the first byte of each frame only.
- R5: Every complete byte of a frame is presented exactly once and in order on `byte_data` with `byte_valid`. The last complete byte carries `byte_eof`. It is seen in the cycle after the second rising clock edge that samples `rx_valid` low.
- R6: If `rx_err` is high in any clock with `rx_valid` high, `byte_err` is high with that frame's `byte_eof`. `byte_err` is never high without `byte_eof`.
- R7: A frame that ends with a leftover nibble (nibble mode) or one to seven leftover bits (serial mode) drops those leftover bits and raises `byte_err` with its `byte_eof`.
- R8: A frame with no complete byte produces no output at all.
- R9: `carrier_sync` follows `carrier_async` after exactly two rising clock edges.
- R10: `collision_sync` follows `collision_async` after two rising clock edges. It is forced low while `full_duplex` is 1.
- R11: The synchronous active-high `rst` clears all outputs and any partly built byte. Bytes pending at reset are never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1: one bit per clock on rx_data[0]; 0: nibble per clock |
| full_duplex | input | 1 | 1: collision output masked |
| rx_valid | input | 1 | Receive data valid, high through the whole frame |
| rx_err | input | 1 | Receive error from the physical-layer device |
| rx_data | input | 4 | Receive data nibble |
| carrier_async | input | 1 | Unsynchronised carrier sense |
| collision_async | input | 1 | Unsynchronised collision detect |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | byte_data holds a byte this cycle |
| byte_sof | output | 1 | First byte of a frame |
| byte_eof | output | 1 | Last complete byte of a frame |
| byte_err | output | 1 | Frame errored or misaligned, with byte_eof |
| carrier_sync | output | 1 | Synchronised carrier sense |
| collision_sync | output | 1 | Synchronised, duplex-masked collision |

## Verification
A wrong shift count or shift direction shows up on the first byte of a frame. It appears as swapped nibbles or a bit-reversed value within two or eight clocks of the frame start. A bit-counter or pending-byte register that is not cleared at the end of a frame carries over into the next frame. There it shows as a missing or extra byte, a misplaced start strobe, or a false error flag, and the first byte of that next frame reveals it. A wrong synchroniser depth shows as the carrier or collision output changing one edge early or late. The mask is seen at once through the duplex input.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              in_frame;
        logic              err_acc;
        logic              done;
        logic [BYTE_W-1:0] byte_o;
        logic              last;
        logic              trail;
        logic              ferr;
    } asm_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] pend;
        logic              pend_v;
        logic              first;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              sof;
        logic              eof;
        logic              err;
    } frm_state_t;

endpackage

// File: rtl/eth_rx_sync.sv
module eth_rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chain_q[0] == $past(async_in))); // R9

    generate
        if (STAGES > 1) begin : g_chain_chk
            AST_SYNC_LAST: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (chain_q[STAGES-1] == $past(chain_q[STAGES-2]))); // R10
        end
    endgenerate

endmodule

// File: rtl/eth_rx_assembler.sv
module eth_rx_assembler
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic [NIB_W-1:0]  rx_data,
    output logic              a_done,
    output logic [BYTE_W-1:0] a_byte,
    output logic              a_last,
    output logic              a_trail,
    output logic              a_ferr
);

    asm_state_t st_d, st_q;

    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  cnt_next;
    logic [BYTE_W-1:0] sh_next;

    always_comb begin
        step     = serial_mode ? CNT_W'(1) : CNT_W'(NIB_W);
        cnt_next = st_q.cnt + step;
        if (serial_mode) begin
            sh_next = {rx_data[0], st_q.shreg[BYTE_W-1:1]};
        end else begin
            sh_next = {rx_data, st_q.shreg[BYTE_W-1:NIB_W]};
        end

        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.last  = 1'b0;
        st_d.trail = 1'b0;
        st_d.ferr  = 1'b0;

        if (rx_valid) begin
            st_d.in_frame = 1'b1;
            st_d.err_acc  = st_q.err_acc | rx_err;
            st_d.shreg    = sh_next;
            if (cnt_next == CNT_W'(BYTE_W)) begin
                st_d.done   = 1'b1;
                st_d.byte_o = sh_next;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = cnt_next;
            end
        end else if (st_q.in_frame) begin
            st_d.last     = 1'b1;
            st_d.trail    = (st_q.cnt != '0);
            st_d.ferr     = st_q.err_acc;
            st_d.in_frame = 1'b0;
            st_d.err_acc  = 1'b0;
            st_d.cnt      = '0;
            st_d.shreg    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_done  = st_q.done;
    assign a_byte  = st_q.byte_o;
    assign a_last  = st_q.last;
    assign a_trail = st_q.trail;
    assign a_ferr  = st_q.ferr;

    AST_NIBBLE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (st_q.in_frame && rx_valid && !serial_mode) |-> (st_q.cnt[1:0] == 2'b00)); // R1

    AST_DONE_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
        st_q.done |-> $past(rx_valid)); // R3

    AST_LAST_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        st_q.last |-> !$past(rx_valid)); // R5

endmodule

// File: rtl/eth_rx_framer.sv
module eth_rx_framer
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_done,
    input  logic [BYTE_W-1:0] a_byte,
    input  logic              a_last,
    input  logic              a_trail,
    input  logic              a_ferr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              byte_sof,
    output logic              byte_eof,
    output logic              byte_err
);

    frm_state_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.ov  = 1'b0;
        fr_d.sof = 1'b0;
        fr_d.eof = 1'b0;
        fr_d.err = 1'b0;

        if (a_done) begin
            if (fr_q.pend_v) begin
                fr_d.ov    = 1'b1;
                fr_d.od    = fr_q.pend;
                fr_d.sof   = fr_q.first;
                fr_d.first = 1'b0;
            end
            fr_d.pend   = a_byte;
            fr_d.pend_v = 1'b1;
        end else if (a_last) begin
            if (fr_q.pend_v) begin
                fr_d.ov  = 1'b1;
                fr_d.od  = fr_q.pend;
                fr_d.sof = fr_q.first;
                fr_d.eof = 1'b1;
                fr_d.err = a_ferr | a_trail;
            end
            fr_d.pend_v = 1'b0;
            fr_d.first  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q       <= '0;
            fr_q.first <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign byte_data  = fr_q.od;
    assign byte_valid = fr_q.ov;
    assign byte_sof   = fr_q.sof;
    assign byte_eof   = fr_q.eof;
    assign byte_err   = fr_q.err;

    AST_ERR_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
        byte_err |-> byte_eof); // R6

    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (byte_sof || byte_eof) |-> byte_valid); // R4

    AST_EOF_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        byte_eof |-> $past(a_last)); // R5

    AST_NO_OUTPUT_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !byte_valid); // R11

endmodule

// File: rtl/eth_rx_front.sv
module eth_rx_front
    import eth_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic              full_duplex,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic [NIB_W-1:0]  rx_data,
    input  logic              carrier_async,
    input  logic              collision_async,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              byte_sof,
    output logic              byte_eof,
    output logic              byte_err,
    output logic              carrier_sync,
    output logic              collision_sync
);

    localparam int LINES = 2;

    logic [LINES-1:0]  sync_q;
    logic              a_done;
    logic [BYTE_W-1:0] a_byte;
    logic              a_last;
    logic              a_trail;
    logic              a_ferr;

    eth_rx_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({collision_async, carrier_async}),
        .sync_out (sync_q)
    );

    eth_rx_assembler u_asm (
        .clk         (clk),
        .rst         (rst),
        .serial_mode (serial_mode),
        .rx_valid    (rx_valid),
        .rx_err      (rx_err),
        .rx_data     (rx_data),
        .a_done      (a_done),
        .a_byte      (a_byte),
        .a_last      (a_last),
        .a_trail     (a_trail),
        .a_ferr      (a_ferr)
    );

    eth_rx_framer u_frm (
        .clk        (clk),
        .rst        (rst),
        .a_done     (a_done),
        .a_byte     (a_byte),
        .a_last     (a_last),
        .a_trail    (a_trail),
        .a_ferr     (a_ferr),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_sof   (byte_sof),
        .byte_eof   (byte_eof),
        .byte_err   (byte_err)
    );

    assign carrier_sync   = sync_q[0];
    assign collision_sync = sync_q[1] & ~full_duplex;

    AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rx_valid)) |-> $stable(serial_mode)); // R2

    AST_FDX_NO_COLLISION: assert property (@(posedge clk) disable iff (rst)
        full_duplex |-> !collision_sync); // R10

endmodule

// File: tb/eth_rx_front_bench.sv
module eth_rx_front_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_mode = 1'b0;
    logic       full_duplex = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_err = 1'b0;
    logic [3:0] rx_data = 4'h0;
    logic       carrier_async = 1'b0;
    logic       collision_async = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid, byte_sof, byte_eof, byte_err;
    logic       carrier_sync, collision_sync;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit prev_v = 1'b0;
    int fall_cyc = 0;
    int eof_cyc = 0;
    int got_n = 0;
    logic [10:0] got [64];

    always #10 clk = ~clk;

    eth_rx_front u_eth_rx_front (
        .clk(clk), .rst(rst), .serial_mode(serial_mode), .full_duplex(full_duplex),
        .rx_valid(rx_valid), .rx_err(rx_err), .rx_data(rx_data),
        .carrier_async(carrier_async), .collision_async(collision_async),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .byte_err(byte_err),
        .carrier_sync(carrier_sync), .collision_sync(collision_sync)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_v && !rx_valid) fall_cyc = cyc;
        prev_v = rx_valid;
        if (byte_valid) begin
            if (got_n < 64) got[got_n] = {byte_sof, byte_eof, byte_err, byte_data};
            got_n = got_n + 1;
        end
        if (byte_eof) eof_cyc = cyc;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int seed, input int i);
        return 8'((seed * 13 + i * 37 + 5) & 255);
    endfunction

    task automatic tick();
        @(posedge clk); #5;
    endtask

    task automatic send_frame(input bit ser, input int nb, input int extra,
                              input int err_unit, input int seed);
        int upb = ser ? 8 : 2;
        int total = nb * upb + extra;
        got_n = 0;
        eof_cyc = -1;
        for (int u = 0; u < total; u++) begin
            logic [7:0] b = exp_byte(seed, u / upb);
            int sub = u % upb;
            tick();
            rx_valid = 1'b1;
            rx_err = (u == err_unit);
            if (ser) rx_data = {~b[sub], b[sub], ~b[sub], b[sub]};
            else rx_data = (sub == 1) ? b[7:4] : b[3:0];
        end
        for (int k = 0; k < 6; k++) begin
            tick();
            rx_valid = 1'b0;
            rx_err = 1'b1;
            rx_data = 4'(k * 5 + seed);
        end
        tick();
        rx_err = 1'b0;
    endtask

    task automatic check_frame(input bit ser, input int nb, input int extra,
                               input bit errd, input int seed);
        string rq = ser ? "R2" : "R1";
        chk(got_n == nb, (nb == 0) ? "R8" : "R5", "byte count", got_n, nb);
        for (int i = 0; i < nb && i < got_n && i < 64; i++) begin
            logic [10:0] e;
            e[7:0] = exp_byte(seed, i);
            e[10] = (i == 0);
            e[9] = (i == nb - 1);
            e[8] = (i == nb - 1) && (errd || extra != 0);
            chk(got[i][7:0] == e[7:0], rq, "byte data", got[i][7:0], e[7:0]);
            chk(got[i][10] == e[10], "R4", "sof flag", got[i][10], e[10]);
            if (e[8] && extra != 0)
                chk(got[i][8] == e[8], "R7", "alignment error", got[i][8], e[8]);
            else
                chk(got[i][9:8] == e[9:8], "R6", "eof/err flags", got[i][9:8], e[9:8]);
        end
        if (nb > 0)
            chk(eof_cyc == fall_cyc + 2, "R5", "eof latency", eof_cyc - fall_cyc, 2);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        chk({byte_valid, byte_sof, byte_eof, byte_err, carrier_sync, collision_sync} == 6'b0,
            "R11", "reset outputs", byte_valid, 0);
        tick();
        rst = 1'b0;
        repeat (2) tick();

        for (int ser = 0; ser < 2; ser++) begin
            serial_mode = ser[0];
            for (int nb = 0; nb <= (ser ? 3 : 5); nb++) begin
                for (int ex = 0; ex <= (ser ? 7 : 1); ex++) begin
                    int total = nb * (ser ? 8 : 2) + ex;
                    int eu = ((nb + ex) % 2 == 1 && total > 0) ? total - 1 : -1;
                    int seed = nb * 7 + ex * 3 + ser * 11;
                    full_duplex = ex[0];
                    send_frame(ser[0], nb, ex, eu, seed);
                    // R3: idle junk with rx_err high must not add bytes or errors
                    check_frame(ser[0], nb, ex, eu >= 0, seed);
                end
            end
        end

        serial_mode = 1'b0;
        got_n = 0;
        for (int u = 0; u < 3; u++) begin
            tick();
            rx_valid = 1'b1;
            rx_data = 4'(u + 9);
        end
        tick();
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (2) tick();
        rst = 1'b0;
        repeat (6) tick();
        chk(got_n == 0, "R11", "bytes after reset", got_n, 0);
        send_frame(1'b0, 2, 0, -1, 40);
        check_frame(1'b0, 2, 0, 1'b0, 40);

        tick();
        carrier_async = 1'b1;
        @(negedge clk);
        chk(carrier_sync == 1'b0, "R9", "carrier before edges", carrier_sync, 0);
        @(posedge clk); @(negedge clk);
        chk(carrier_sync == 1'b0, "R9", "carrier after one edge", carrier_sync, 0);
        @(posedge clk); @(negedge clk);
        chk(carrier_sync == 1'b1, "R9", "carrier after two edges", carrier_sync, 1);

        tick();
        full_duplex = 1'b1;
        collision_async = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(collision_sync == 1'b0, "R10", "collision masked e1", collision_sync, 0);
        @(posedge clk); @(negedge clk);
        chk(collision_sync == 1'b0, "R10", "collision masked e2", collision_sync, 0);
        tick();
        full_duplex = 1'b0;
        @(negedge clk);
        chk(collision_sync == 1'b1, "R10", "collision half duplex", collision_sync, 1);
        tick();
        collision_async = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(collision_sync == 1'b1, "R10", "collision one edge", collision_sync, 1);
        @(posedge clk); @(negedge clk);
        chk(collision_sync == 1'b0, "R10", "collision cleared", collision_sync, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule